// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block drives the command, address, bank, clock-enable and byte-mask pins of a single-data-rate SDRAM through the fixed command sequence that the memory needs once its supply and clock are stable. A one-cycle start pulse launches the run. The block then presents one command per clock: a deselect, a group of NOPs, a precharge of every bank, two auto-refresh commands separated by NOPs, and a load of the mode register. After two closing NOPs it raises a done flag. The surrounding controller is expected to handle the power-up wait before start, and to take over the pins once done is high.

The mode word is built by a package function from its fields. These fields are burst length 1 (code 000), sequential burst type, CAS latency 3, a standard operating mode, and single-location writes. With those values the word is 0x230. Every output is registered to the controller clock. For the whole time the block runs, clock enable stays high and every data byte stays masked.

Top module: `sdram_init_seq`

## Requirements
- R1: During and after a synchronous reset, the outputs are as follows: cmd_o is deselect (1111), addr_o and bank_o are zero, cke_o is 1, every dqm_o bit is 1, and done_o is 0.
- R2: cmd_o carries {chip select, row strobe, column strobe, write enable}, all active low. Deselect is 1111, NOP is 0111, precharge is 0010, auto-refresh is 0001 and load mode is 0000.
- R3: When start is sampled high while the block is idle, the command for step i appears on cmd_o after the (i+2)-th rising edge, counting the sampling edge as the first. There are 20 steps, indexed 0 to 19. Step 0 is deselect, steps 1-5 are NOP, step 6 is precharge, steps 7-10 are NOP, step 11 is refresh, steps 12-13 are NOP, step 14 is refresh, steps 15-16 are NOP, step 17 is load mode, and steps 18-19 are NOP.
- R4: The precharge step drives address bit 10 high and every other address bit low (addr_o = 0x400), with bank_o = 0. This selects all banks. A single-bank form would drive bit 10 low and name the bank on bank_o.
- R5: The load-mode step drives the mode word on addr_o with bank_o = 0. In that word, bits [2:0] = 000 (burst of 1), bit 3 = 0 (sequential), bits [6:4] = 011 (CAS latency 3), bits [8:7] = 00, and bit 9 = 1 (single-location write). The result is 0x230.
- R6: cke_o is 1 and dqm_o is all ones on every cycle.
- R7: done_o rises one cycle after the last NOP, together with deselect on cmd_o. It stays high, with deselect, until the next accepted start or a reset.
- R8: A start pulse sampled while the sequence is running has no effect on any output.
- R9: A reset asserted in the middle of a run returns the block to the idle state of R1 on the next edge, and the sequence does not resume.
- R10: On every deselect, NOP and refresh step, addr_o and bank_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to run the sequence |
| cmd_o | output | 4 | {cs_n, ras_n, cas_n, we_n} command |
| addr_o | output | ADDR_W (12) | Address bus |
| bank_o | output | BANK_W (2) | Bank select |
| cke_o | output | 1 | Clock enable, held high |
| dqm_o | output | DQM_W (4) | Byte masks, held high |
| done_o | output | 1 | Sequence finished |

## Verification
The bench builds the block with its default parameters: a 12-bit address, 2 bank bits, 4 mask bits and the 5/4/2/2 NOP spacing. These defaults give the 20-step order and the 0x230 mode word, so the bench can compare each command against a list it writes out independently of the RTL. Random idle gaps, start pulses injected at random steps of a run, and resets at random steps exercise the acceptance of start, the point at which start is ignored, and recovery from reset across every step index.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [3:0] {
    CMD_DESEL = 4'b1111,
    CMD_NOP   = 4'b0111,
    CMD_BST   = 4'b0110,
    CMD_RD    = 4'b0101,
    CMD_WR    = 4'b0100,
    CMD_ACT   = 4'b0011,
    CMD_PRE   = 4'b0010,
    CMD_REF   = 4'b0001,
    CMD_LMR   = 4'b0000
  } cmd_e;

  localparam logic [2:0] BL_ONE   = 3'b000;
  localparam logic       BT_SEQ   = 1'b0;
  localparam logic [2:0] CL_THREE = 3'd3;

  // Assemble the 12-bit mode word from its fields
  function automatic logic [11:0] mode_word(input logic [2:0] blen,
                                            input logic       btype,
                                            input logic [2:0] cas,
                                            input logic       single_wr);
    logic [11:0] w;
    w       = '0;
    w[2:0]  = blen;
    w[3]    = btype;
    w[6:4]  = cas;
    w[8:7]  = 2'b00;
    w[9]    = single_wr;
    return w;
  endfunction

  // Precharge address: auto-precharge bit selects all banks
  function automatic logic [11:0] pall_word(input int ap_bit);
    logic [11:0] w;
    w         = '0;
    w[ap_bit] = 1'b1;
    return w;
  endfunction

endpackage

// File: rtl/sdram_init_ctrl.sv
module sdram_init_ctrl #(
  parameter int STEP_W = 5,
  parameter int LAST   = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic [STEP_W-1:0] idx,
  output logic              fin,
  output logic              ev_accept,
  output logic              ev_last
);
  assign ev_accept = start && !busy;
  assign ev_last   = busy && (idx == STEP_W'(LAST));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      idx  <= '0;
      fin  <= 1'b0;
    end else if (busy) begin
      if (ev_last) begin
        busy <= 1'b0;
        fin  <= 1'b1;
      end else begin
        idx <= idx + 1'b1;
      end
    end else if (ev_accept) begin
      busy <= 1'b1;
      idx  <= '0;
      fin  <= 1'b0;
    end
  end
endmodule

// File: rtl/sdram_init_decode.sv
module sdram_init_decode
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BANK_W = 2,
  parameter int STEP_W = 5,
  parameter int P_PALL = 6,
  parameter int P_REF1 = 11,
  parameter int P_REF2 = 14,
  parameter int P_LMR  = 17,
  parameter int AP_BIT = 10
) (
  input  logic              busy,
  input  logic [STEP_W-1:0] idx,
  input  logic              fin,
  output logic [3:0]        cmd,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic              done
);
  localparam logic [11:0] MODE_W = mode_word(BL_ONE, BT_SEQ, CL_THREE, 1'b1);
  localparam logic [11:0] PALL_W = pall_word(AP_BIT);

  always_comb begin
    cmd  = CMD_DESEL;
    addr = '0;
    bank = '0;
    done = fin && !busy;
    if (busy) begin
      if (idx == '0) begin
        cmd = CMD_DESEL;
      end else if (idx == STEP_W'(P_PALL)) begin
        cmd  = CMD_PRE;
        addr = ADDR_W'(PALL_W);
      end else if (idx == STEP_W'(P_REF1) || idx == STEP_W'(P_REF2)) begin
        cmd = CMD_REF;
      end else if (idx == STEP_W'(P_LMR)) begin
        cmd  = CMD_LMR;
        addr = ADDR_W'(MODE_W);
      end else begin
        cmd = CMD_NOP;
      end
    end
  end
endmodule

// File: rtl/sdram_init_outreg.sv
module sdram_init_outreg #(
  parameter int ADDR_W = 12,
  parameter int BANK_W = 2,
  parameter int DQM_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        cmd_d,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic [BANK_W-1:0] bank_d,
  input  logic              done_d,
  output logic [3:0]        cmd_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [BANK_W-1:0] bank_q,
  output logic              cke_q,
  output logic [DQM_W-1:0]  dqm_q,
  output logic              done_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= 4'b1111;
      addr_q <= '0;
      bank_q <= '0;
      done_q <= 1'b0;
    end else begin
      cmd_q  <= cmd_d;
      addr_q <= addr_d;
      bank_q <= bank_d;
      done_q <= done_d;
    end
    cke_q <= 1'b1;
    dqm_q <= '1;
  end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq #(
  parameter int ADDR_W    = 12,
  parameter int BANK_W    = 2,
  parameter int DQM_W     = 4,
  parameter int LEAD_NOPS = 5,
  parameter int PALL_GAP  = 4,
  parameter int REF_GAP   = 2,
  parameter int LMR_GAP   = 2,
  parameter int AP_BIT    = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic [3:0]        cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              cke_o,
  output logic [DQM_W-1:0]  dqm_o,
  output logic              done_o
);
  localparam int P_PALL = 1 + LEAD_NOPS;
  localparam int P_REF1 = P_PALL + 1 + PALL_GAP;
  localparam int P_REF2 = P_REF1 + 1 + REF_GAP;
  localparam int P_LMR  = P_REF2 + 1 + REF_GAP;
  localparam int LAST   = P_LMR + LMR_GAP;
  localparam int STEP_W = $clog2(LAST + 1);

  logic              seq_busy;
  logic [STEP_W-1:0] seq_idx;
  logic              seq_fin;
  logic              seq_accept;
  logic              seq_last;
  logic [3:0]        nxt_cmd;
  logic [ADDR_W-1:0] nxt_addr;
  logic [BANK_W-1:0] nxt_bank;
  logic              nxt_done;

  sdram_init_ctrl #(.STEP_W(STEP_W), .LAST(LAST)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .busy(seq_busy), .idx(seq_idx), .fin(seq_fin),
    .ev_accept(seq_accept), .ev_last(seq_last)
  );

  sdram_init_decode #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .STEP_W(STEP_W),
    .P_PALL(P_PALL), .P_REF1(P_REF1), .P_REF2(P_REF2),
    .P_LMR(P_LMR), .AP_BIT(AP_BIT)
  ) u_dec (
    .busy(seq_busy), .idx(seq_idx), .fin(seq_fin),
    .cmd(nxt_cmd), .addr(nxt_addr), .bank(nxt_bank), .done(nxt_done)
  );

  sdram_init_outreg #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .DQM_W(DQM_W)) u_out (
    .clk(clk), .rst(rst),
    .cmd_d(nxt_cmd), .addr_d(nxt_addr), .bank_d(nxt_bank), .done_d(nxt_done),
    .cmd_q(cmd_o), .addr_q(addr_o), .bank_q(bank_o),
    .cke_q(cke_o), .dqm_q(dqm_o), .done_q(done_o)
  );
endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
  parameter int ADDR_W = 12,
  parameter int BANK_W = 2,
  parameter int DQM_W  = 4,
  parameter int AP_BIT = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              last,
  input logic [3:0]        cmd,
  input logic [ADDR_W-1:0] addr,
  input logic [BANK_W-1:0] bank,
  input logic              cke,
  input logic [DQM_W-1:0]  dqm,
  input logic              done
);
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (cmd == 4'b1111 && !done && addr == '0 && bank == '0));

  p_pall_addr_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0010) |-> (addr[AP_BIT] && bank == '0));

  p_mode_word_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0000) |-> (addr == ADDR_W'(12'h230) && bank == '0));

  p_cke_dqm_r6: assert property (@(posedge clk) disable iff (rst)
    (cke == 1'b1 && dqm == '1));

  p_done_after_nop_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(cmd) == 4'b0111 && cmd == 4'b1111));

  p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (cmd == 4'b1111));

  p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !last) |=> busy);

  p_quiet_addr_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0111 || cmd == 4'b1111 || cmd == 4'b0001) |-> (addr == '0 && bank == '0));
endmodule

bind sdram_init_seq sdram_init_chk #(
  .ADDR_W(ADDR_W), .BANK_W(BANK_W), .DQM_W(DQM_W), .AP_BIT(AP_BIT)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(seq_busy), .last(seq_last),
  .cmd(cmd_o), .addr(addr_o), .bank(bank_o), .cke(cke_o), .dqm(dqm_o),
  .done(done_o)
);

// File: tb/sdram_init_seq_bench.sv
module sdram_init_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NSTEPS     = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  cmd_o;
  logic [11:0] addr_o;
  logic [1:0]  bank_o;
  logic        cke_o;
  logic [3:0]  dqm_o;
  logic        done_o;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  sdram_init_seq u_sdram_init_seq (
    .clk(clk), .rst(rst), .start(start), .cmd_o(cmd_o), .addr_o(addr_o),
    .bank_o(bank_o), .cke_o(cke_o), .dqm_o(dqm_o), .done_o(done_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Expected command per step, written from the required order (R2/R3)
  function automatic logic [3:0] exp_cmd(input int i);
    case (i)
      0:       return 4'b1111;
      6:       return 4'b0010;
      11, 14:  return 4'b0001;
      17:      return 4'b0000;
      default: return 4'b0111;
    endcase
  endfunction

  // Expected address per step (R4, R5, R10)
  function automatic logic [11:0] exp_addr(input int i);
    if (i == 6)  return 12'h001 << 10;
    if (i == 17) return (12'h001 << 9) | (12'h003 << 4);
    return 12'h000;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, got, exp);
    end
  endtask

  task automatic check_idle(input string req, input logic exp_done);
    check(req, "idle cmd", 32'(cmd_o), 32'h0000000f);
    check(req, "idle addr", 32'(addr_o), 32'h0);
    check(req, "idle bank", 32'(bank_o), 32'h0);
    check(req, "idle done", 32'(done_o), 32'(exp_done));
    check("R6", "cke/dqm", {27'h0, cke_o, dqm_o}, 32'h1f);
  endtask

  task automatic check_step(input int i);
    string rq;
    rq = (i == 6) ? "R4" : (i == 17) ? "R5" : "R3";
    check(rq, $sformatf("cmd step %0d", i), 32'(cmd_o), 32'(exp_cmd(i)));
    check((i == 6 || i == 17) ? rq : "R10", $sformatf("addr step %0d", i),
          32'(addr_o), 32'(exp_addr(i)));
    check("R10", "bank", 32'(bank_o), 32'h0);
    check("R6", "cke/dqm", {27'h0, cke_o, dqm_o}, 32'h1f);
    check("R7", "done low while running", 32'(done_o), 32'h0);
  endtask

  // mode: 0 plain, 1 noisy start during run (R8), 2 reset at step rst_at (R9)
  task automatic run_seq(input int mode, input int rst_at);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < NSTEPS; i++) begin
      @(negedge clk);
      check_step(i);
      if (mode == 2 && i == rst_at) begin
        rst = 1'b1;
        @(negedge clk);
        check_idle("R9", 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check_idle("R9", 1'b0);
        return;
      end
      if (mode == 1) start = (i <= 18) ? 1'($urandom_range(0, 1)) : 1'b0;
    end
    start = 1'b0;
    @(negedge clk);
    check("R7", "done after last NOP", 32'(done_o), 32'h1);
    check("R7", "deselect with done", 32'(cmd_o), 32'hf);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check_idle("R1", 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check_idle("R1", 1'b0);

    run_seq(0, 0);
    repeat (4) begin
      @(negedge clk);
      check_idle("R7", 1'b1);
    end

    run_seq(1, 0);
    run_seq(2, 0);
    run_seq(2, 19);

    for (int k = 0; k < 12; k++) begin
      int gap;
      int md;
      gap = $urandom_range(0, 5);
      md  = $urandom_range(0, 2);
      repeat (gap) @(negedge clk);
      run_seq(md, $urandom_range(0, NSTEPS - 1));
    end

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check_idle("R1", 1'b0);
    rst = 1'b0;

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule